// File: doc/BRIEF.md
# Split Translation Buffer with Pinned Entries

This block translates virtual page addresses to physical ones through two storage groups that are searched together. A small fully associative set of pinned slots is filled only by explicit software writes and is never touched by replacement. Beside it sits a translation cache whose slots are filled by an insert command and overwritten in round-robin order. Every slot carries its own page-size code, so a large page and a small page can sit next to each other.

A lookup is a valid/ready stream. The upper three address bits pick one of eight region registers, and the region identifier held there must equal the one stored in the slot. A hit returns the physical address, with the page offset carried through from the virtual address, and the slot's access-rights, privilege and protection-key fields. The key is then compared with a bank of key registers, and a key fault is flagged when none of them holds it. The result sits in a single output register. The lookup side accepts a new request only when that register is empty or is being drained in the same cycle, so a stalled consumer holds back the producer without losing or reordering results. Commands arrive on a plain one-cycle strobe.

Top module: `tlb_split`

## Requirements
- R1: A pinned write (cmd_op 1) stores the command fields with its valid flag set into slot cmd_idx. A later matching lookup returns rs_hit=1 and rs_pinned=1, along with that slot's rs_ar, rs_pl and rs_key.
- R2: A cache insert (cmd_op 2) writes the slot named by a pointer that is 0 after reset. The pointer steps by one per insert and wraps from TC_N-1 to 0. The slot it names is overwritten whether or not it is valid, and pinned slots are never written.
- R3: When a pinned slot and a cache slot both match, the pinned slot's data is returned with rs_pinned=1.
- R4: Page-size codes 0 to 10 select offsets of 12, 13, 14, 16, 18, 20, 22, 24, 26, 28 and 32 bits. Codes 11 to 15 act as 12 bits. Only the address bits above the offset take part in the match. rs_pa is the slot's physical address above the offset, joined with the lookup address below it.
- R5: Bits VA_W-1..VA_W-3 of the lookup address pick a region register, written by cmd_op 4 with cmd_idx[2:0] and cmd_rid. A slot hits only if its region identifier equals that register's value.
- R6: Key registers are written by cmd_op 5 with cmd_idx and cmd_key, and all are empty after reset. On a hit, rs_key_fault=1 if no written key register holds the slot's key. rs_key_fault is never 1 without rs_hit.
- R7: Invalidate-all (cmd_op 3) empties every cache slot and leaves every pinned slot as it was.
- R8: A lookup accepted at a clock edge (lk_valid and lk_ready both high) has its result on the rs_* outputs, with rs_valid=1, right after that edge.
- R9: lk_ready is low while rs_valid=1 and rs_ready=0. While held this way, the rs_* outputs stay constant.
- R10: After reset, rs_valid=0, lk_ready=1, and every lookup misses.
- R11: A miss returns rs_hit=0, rs_pinned=0, rs_key_fault=0 and rs_pa=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | 1 pinned write, 2 cache insert, 3 invalidate cache, 4 region write, 5 key write |
| cmd_idx | input | IDX_W | Slot, region or key index |
| cmd_va | input | VA_W | Virtual address of the new slot |
| cmd_rid | input | RID_W | Region identifier for a slot or region register |
| cmd_pa | input | PA_W | Physical address of the new slot |
| cmd_ps | input | 4 | Page-size code |
| cmd_ar | input | 3 | Access-rights field |
| cmd_pl | input | 2 | Privilege-level field |
| cmd_key | input | KEY_W | Protection key for a slot or key register |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_va | input | VA_W | Lookup virtual address |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Consumer takes result |
| rs_hit | output | 1 | Translation found |
| rs_pinned | output | 1 | Result came from a pinned slot |
| rs_pa | output | PA_W | Physical address |
| rs_ar | output | 3 | Access-rights field |
| rs_pl | output | 2 | Privilege-level field |
| rs_key | output | KEY_W | Protection key of the slot |
| rs_key_fault | output | 1 | No key register holds the slot's key |

## Verification
The assertions check the rules that hold on every cycle. An accepted lookup must produce a result after exactly one edge, a stalled result must stay frozen, and a fault can only come with a hit. A miss must return a zero address. The replacement pointer must move by exactly one per insert, and invalidate-all must empty the cache while leaving the pinned valid flags alone. Some behaviour depends on stored contents, and only the directed scenarios can show it: the offset width for each page size, the region-identifier compare, pinned priority over a cache hit, the eviction of the oldest cache slot on wrap, and a fault clearing once a key register is written.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PIN_WR  = 3'd1,
    OP_TC_INS  = 3'd2,
    OP_TC_INV  = 3'd3,
    OP_RR_WR   = 3'd4,
    OP_KEY_WR  = 3'd5
  } tlb_op_e;

  localparam int RSEL_W = 3;
  localparam int RR_N   = 1 << RSEL_W;

  // offset width for a page-size code
  function automatic int unsigned page_shift(input logic [3:0] code);
    case (code)
      4'd0:    return 12;
      4'd1:    return 13;
      4'd2:    return 14;
      4'd3:    return 16;
      4'd4:    return 18;
      4'd5:    return 20;
      4'd6:    return 22;
      4'd7:    return 24;
      4'd8:    return 26;
      4'd9:    return 28;
      4'd10:   return 32;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match #(
  parameter int VA_W  = 48,
  parameter int RID_W = 18
) (
  input  logic             e_valid,
  input  logic [VA_W-1:0]  e_va,
  input  logic [RID_W-1:0] e_rid,
  input  logic [3:0]       e_ps,
  input  logic [VA_W-1:0]  q_va,
  input  logic [RID_W-1:0] q_rid,
  output logic             hit
);
  import tlb_pkg::*;
  logic [VA_W-1:0] keep;

  assign keep = {VA_W{1'b1}} << page_shift(e_ps);
  assign hit  = e_valid && (e_rid == q_rid) && (((e_va ^ q_va) & keep) == '0);
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N = 8,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (adv)
      ptr <= (int'(ptr) == N - 1) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_key_check.sv
module tlb_key_check #(
  parameter int KEYS  = 16,
  parameter int KEY_W = 16,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] probe_key,
  output logic             key_ok
);
  logic [KEY_W-1:0] key_q [KEYS];
  logic [KEYS-1:0]  used_q;
  logic [KEYS-1:0]  eq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int i = 0; i < KEYS; i++) key_q[i] <= '0;
    end else if (wr_en && int'(wr_idx) < KEYS) begin
      used_q[wr_idx] <= 1'b1;
      key_q[wr_idx]  <= wr_key;
    end
  end

  for (genvar g = 0; g < KEYS; g++) begin : g_cmp
    assign eq[g] = used_q[g] && (key_q[g] == probe_key);
  end

  assign key_ok = |eq;
endmodule

// File: rtl/tlb_split.sv
module tlb_split #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 40,
  parameter int RID_W = 18,
  parameter int KEY_W = 16,
  parameter int PIN_N = 4,
  parameter int TC_N  = 8,
  parameter int KEY_N = 16,
  localparam int IDX_MAX = (PIN_N > KEY_N) ? ((PIN_N > 8) ? PIN_N : 8)
                                           : ((KEY_N > 8) ? KEY_N : 8),
  localparam int IDX_W = $clog2(IDX_MAX),
  localparam int PTR_W = (TC_N > 1) ? $clog2(TC_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [VA_W-1:0]  cmd_va,
  input  logic [RID_W-1:0] cmd_rid,
  input  logic [PA_W-1:0]  cmd_pa,
  input  logic [3:0]       cmd_ps,
  input  logic [2:0]       cmd_ar,
  input  logic [1:0]       cmd_pl,
  input  logic [KEY_W-1:0] cmd_key,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_va,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic             rs_hit,
  output logic             rs_pinned,
  output logic [PA_W-1:0]  rs_pa,
  output logic [2:0]       rs_ar,
  output logic [1:0]       rs_pl,
  output logic [KEY_W-1:0] rs_key,
  output logic             rs_key_fault
);
  import tlb_pkg::*;

  typedef struct packed {
    logic             valid;
    logic [VA_W-1:0]  va;
    logic [RID_W-1:0] rid;
    logic [PA_W-1:0]  pa;
    logic [3:0]       ps;
    logic [2:0]       ar;
    logic [1:0]       pl;
    logic [KEY_W-1:0] key;
  } ent_t;

  ent_t             pin_q [PIN_N];
  ent_t             tc_q  [TC_N];
  logic [RID_W-1:0] rr_q  [RR_N];
  ent_t             new_ent;
  logic [PTR_W-1:0] tc_ptr;
  logic [PIN_N-1:0] pin_hit, pin_valid_vec;
  logic [TC_N-1:0]  tc_hit, tc_valid_vec;
  logic [RID_W-1:0] q_rid;
  ent_t             sel;
  logic             sel_pin;
  logic [PA_W-1:0]  keep_pa, out_pa;
  logic             key_ok;
  logic             accept;
  tlb_op_e          op;

  assign op = tlb_op_e'(cmd_op);

  always_comb begin
    new_ent       = '0;
    new_ent.valid = 1'b1;
    new_ent.va    = cmd_va;
    new_ent.rid   = cmd_rid;
    new_ent.pa    = cmd_pa;
    new_ent.ps    = cmd_ps;
    new_ent.ar    = cmd_ar;
    new_ent.pl    = cmd_pl;
    new_ent.key   = cmd_key;
  end

  // slot storage and command decode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PIN_N; i++) pin_q[i] <= '0;
      for (int i = 0; i < TC_N; i++)  tc_q[i]  <= '0;
      for (int i = 0; i < RR_N; i++)  rr_q[i]  <= '0;
    end else if (cmd_valid) begin
      case (op)
        OP_PIN_WR: if (int'(cmd_idx) < PIN_N) pin_q[cmd_idx] <= new_ent;
        OP_TC_INS: tc_q[tc_ptr] <= new_ent;
        OP_TC_INV: for (int i = 0; i < TC_N; i++) tc_q[i].valid <= 1'b0;
        OP_RR_WR:  rr_q[cmd_idx[RSEL_W-1:0]] <= cmd_rid;
        default:   ;
      endcase
    end
  end

  tlb_rr_ptr #(.N(TC_N)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (cmd_valid && op == OP_TC_INS),
    .ptr  (tc_ptr)
  );

  assign q_rid = rr_q[lk_va[VA_W-1 -: RSEL_W]];

  for (genvar g = 0; g < PIN_N; g++) begin : g_pin
    assign pin_valid_vec[g] = pin_q[g].valid;
    tlb_entry_match #(.VA_W(VA_W), .RID_W(RID_W)) u_m (
      .e_valid(pin_q[g].valid), .e_va(pin_q[g].va), .e_rid(pin_q[g].rid),
      .e_ps(pin_q[g].ps), .q_va(lk_va), .q_rid(q_rid), .hit(pin_hit[g])
    );
  end

  for (genvar g = 0; g < TC_N; g++) begin : g_tc
    assign tc_valid_vec[g] = tc_q[g].valid;
    tlb_entry_match #(.VA_W(VA_W), .RID_W(RID_W)) u_m (
      .e_valid(tc_q[g].valid), .e_va(tc_q[g].va), .e_rid(tc_q[g].rid),
      .e_ps(tc_q[g].ps), .q_va(lk_va), .q_rid(q_rid), .hit(tc_hit[g])
    );
  end

  // lowest index wins; pinned group overrides cache group
  always_comb begin
    sel     = '0;
    sel_pin = 1'b0;
    for (int i = TC_N - 1; i >= 0; i--)
      if (tc_hit[i]) sel = tc_q[i];
    for (int i = PIN_N - 1; i >= 0; i--)
      if (pin_hit[i]) begin
        sel     = pin_q[i];
        sel_pin = 1'b1;
      end
  end

  assign keep_pa = {PA_W{1'b1}} << page_shift(sel.ps);
  assign out_pa  = sel.valid ? ((sel.pa & keep_pa) | (PA_W'(lk_va) & ~keep_pa)) : '0;

  tlb_key_check #(.KEYS(KEY_N), .KEY_W(KEY_W), .IW(IDX_W)) u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cmd_valid && op == OP_KEY_WR),
    .wr_idx   (cmd_idx),
    .wr_key   (cmd_key),
    .probe_key(sel.key),
    .key_ok   (key_ok)
  );

  // single result register with back-pressure
  assign lk_ready = !rs_valid || rs_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid     <= 1'b0;
      rs_hit       <= 1'b0;
      rs_pinned    <= 1'b0;
      rs_pa        <= '0;
      rs_ar        <= '0;
      rs_pl        <= '0;
      rs_key       <= '0;
      rs_key_fault <= 1'b0;
    end else if (accept) begin
      rs_valid     <= 1'b1;
      rs_hit       <= sel.valid;
      rs_pinned    <= sel_pin;
      rs_pa        <= out_pa;
      rs_ar        <= sel.ar;
      rs_pl        <= sel.pl;
      rs_key       <= sel.key;
      rs_key_fault <= sel.valid && !key_ok;
    end else if (rs_ready) begin
      rs_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_split_chk.sv
module tlb_split_chk #(
  parameter int PA_W  = 40,
  parameter int PIN_N = 4,
  parameter int TC_N  = 8,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rs_valid,
  input logic             rs_ready,
  input logic             rs_hit,
  input logic             rs_pinned,
  input logic             rs_key_fault,
  input logic [PA_W-1:0]  rs_pa,
  input logic [PIN_N-1:0] pin_valid_vec,
  input logic [TC_N-1:0]  tc_valid_vec,
  input logic [PTR_W-1:0] tc_ptr
);
  assert_accept_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rs_valid);

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_pa) && $stable(rs_hit)
                             && $stable(rs_pinned) && $stable(rs_key_fault));

  assert_fault_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_key_fault |-> rs_hit);

  assert_miss_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_hit |-> rs_pa == '0 && !rs_pinned);

  assert_inv_keeps_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd3 |=> tc_valid_vec == '0 && $stable(pin_valid_vec));

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd2 |=>
      tc_ptr == ((int'($past(tc_ptr)) == TC_N - 1) ? '0 : $past(tc_ptr) + 1'b1));
endmodule

bind tlb_split tlb_split_chk #(
  .PA_W(PA_W), .PIN_N(PIN_N), .TC_N(TC_N), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .rs_valid(rs_valid),
  .rs_ready(rs_ready), .rs_hit(rs_hit), .rs_pinned(rs_pinned),
  .rs_key_fault(rs_key_fault), .rs_pa(rs_pa), .pin_valid_vec(pin_valid_vec),
  .tc_valid_vec(tc_valid_vec), .tc_ptr(tc_ptr)
);

// File: tb/tlb_split_test.sv
`timescale 1ns/1ps
module tlb_split_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [4:0]  cmd_idx = '0;
  logic [47:0] cmd_va = '0;
  logic [17:0] cmd_rid = '0;
  logic [39:0] cmd_pa = '0;
  logic [3:0]  cmd_ps = '0;
  logic [2:0]  cmd_ar = '0;
  logic [1:0]  cmd_pl = '0;
  logic [15:0] cmd_key = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [47:0] lk_va = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic        rs_hit, rs_pinned, rs_key_fault;
  logic [39:0] rs_pa;
  logic [2:0]  rs_ar;
  logic [1:0]  rs_pl;
  logic [15:0] rs_key;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tlb_split uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input int idx, input logic [47:0] va,
                     input logic [17:0] rid, input logic [39:0] pa, input logic [3:0] ps,
                     input logic [2:0] ar, input logic [1:0] pl, input logic [15:0] key);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = 5'(idx); cmd_va = va; cmd_rid = rid;
    cmd_pa = pa; cmd_ps = ps; cmd_ar = ar; cmd_pl = pl; cmd_key = key;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // one edge between request and sampled result
  task automatic lookup(input logic [47:0] va);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [47:0] va,
                            input logic [39:0] pa, input bit pinned);
    lookup(va);
    check(rs_valid == 1'b1, req, 64'(rs_valid), 64'd1);
    check(rs_hit == 1'b1, req, 64'(rs_hit), 64'd1);
    check(rs_pa == pa, req, 64'(rs_pa), 64'(pa));
    check(rs_pinned == pinned, req, 64'(rs_pinned), 64'(pinned));
  endtask

  task automatic expect_miss(input string req, input logic [47:0] va);
    lookup(va);
    check(rs_hit == 1'b0 && rs_valid, req, 64'(rs_hit), 64'd0);
    check(rs_pa == '0 && !rs_key_fault && !rs_pinned, {req, " R11"}, 64'(rs_pa), 64'd0);
  endtask

  task automatic t_reset;
    check(rs_valid == 1'b0, "R10 rs_valid", 64'(rs_valid), 64'd0);
    check(lk_ready == 1'b1, "R10 lk_ready", 64'(lk_ready), 64'd1);
    expect_miss("R10 empty", 48'h0000_1234_5ABC);
  endtask

  task automatic t_pinned;
    cmd(3'd4, 0, '0, 18'd5, '0, 4'd0, 3'd0, 2'd0, '0);
    cmd(3'd5, 0, '0, '0, '0, 4'd0, 3'd0, 2'd0, 16'h0011);
    cmd(3'd1, 1, 48'h0000_1234_5000, 18'd5, 40'hAB_CDEF_0000, 4'd0, 3'd5, 2'd2, 16'h0011);
    expect_hit("R1 R8 pinned", 48'h0000_1234_5ABC, 40'hAB_CDEF_0ABC, 1'b1);
    check(rs_ar == 3'd5 && rs_pl == 2'd2, "R1 ar/pl", 64'({rs_ar, rs_pl}), 64'({3'd5, 2'd2}));
    check(rs_key == 16'h0011 && !rs_key_fault, "R1 key", 64'(rs_key), 64'h11);
    expect_miss("R11 next page", 48'h0000_1234_6ABC);
  endtask

  task automatic t_pagesize;
    cmd(3'd1, 2, 48'h0000_4560_0000, 18'd5, 40'h00_7700_0000, 4'd5, 3'd1, 2'd0, 16'h0011);
    expect_hit("R4 1M", 48'h0000_456A_BCDE, 40'h00_770A_BCDE, 1'b1);
    expect_miss("R4 1M above", 48'h0000_4570_0000);
    cmd(3'd1, 3, 48'h0001_0000_0000, 18'd5, 40'h20_0000_0000, 4'd10, 3'd1, 2'd0, 16'h0011);
    expect_hit("R4 4G", 48'h0001_DEAD_BEEF, 40'h20_DEAD_BEEF, 1'b1);
    expect_miss("R4 4G above", 48'h0002_0000_0000);
  endtask

  task automatic t_region;
    cmd(3'd4, 1, '0, 18'd9, '0, 4'd0, 3'd0, 2'd0, '0);
    cmd(3'd1, 0, 48'h2000_0000_8000, 18'd9, 40'h00_0003_3000, 4'd0, 3'd0, 2'd0, 16'h0011);
    expect_hit("R5 region 1", 48'h2000_0000_8123, 40'h00_0003_3123, 1'b1);
    cmd(3'd4, 1, '0, 18'd10, '0, 4'd0, 3'd0, 2'd0, '0);
    expect_miss("R5 rid changed", 48'h2000_0000_8123);
  endtask

  task automatic t_cache_fill;
    for (int i = 0; i < 9; i++) begin
      cmd(3'd2, 0, 48'h0000_00A0_0000 + 48'(i) * 48'h1000, 18'd5,
          40'h01_0000_0000 + 40'(i) * 40'h1000, 4'd0, 3'd1, 2'd3, 16'h0011);
      if (i == 7)
        for (int j = 0; j < 8; j++)
          expect_hit("R2 filled", 48'h0000_00A0_0000 + 48'(j) * 48'h1000,
                     40'h01_0000_0000 + 40'(j) * 40'h1000, 1'b0);
    end
    expect_miss("R2 oldest evicted", 48'h0000_00A0_0000);
    expect_hit("R2 newest", 48'h0000_00A0_8000, 40'h01_0000_8000, 1'b0);
    expect_hit("R2 neighbour kept", 48'h0000_00A0_7000, 40'h01_0000_7000, 1'b0);
  endtask

  task automatic t_priority;
    cmd(3'd2, 0, 48'h0000_0BB0_0000, 18'd5, 40'h05_0000_0000, 4'd0, 3'd1, 2'd0, 16'h0011);
    expect_hit("R3 cache only", 48'h0000_0BB0_0000, 40'h05_0000_0000, 1'b0);
    cmd(3'd1, 0, 48'h0000_0BB0_0000, 18'd5, 40'h06_0000_0000, 4'd0, 3'd1, 2'd0, 16'h0011);
    expect_hit("R3 pinned wins", 48'h0000_0BB0_0000, 40'h06_0000_0000, 1'b1);
  endtask

  task automatic t_key;
    cmd(3'd1, 1, 48'h0000_0CC0_0000, 18'd5, 40'h07_0000_0000, 4'd0, 3'd1, 2'd0, 16'h0022);
    expect_hit("R6 hit", 48'h0000_0CC0_0010, 40'h07_0000_0010, 1'b1);
    check(rs_key_fault == 1'b1, "R6 fault", 64'(rs_key_fault), 64'd1);
    cmd(3'd5, 5, '0, '0, '0, 4'd0, 3'd0, 2'd0, 16'h0022);
    lookup(48'h0000_0CC0_0010);
    check(rs_key_fault == 1'b0 && rs_hit, "R6 key present", 64'(rs_key_fault), 64'd0);
  endtask

  task automatic t_invalidate;
    cmd(3'd3, 0, '0, '0, '0, 4'd0, 3'd0, 2'd0, '0);
    expect_miss("R7 cache cleared", 48'h0000_00A0_8000);
    expect_miss("R7 cache cleared 2", 48'h0000_00A0_2000);
    expect_hit("R7 pin kept", 48'h0000_0BB0_0000, 40'h06_0000_0000, 1'b1);
    expect_hit("R7 pin kept 2", 48'h0000_456A_BCDE, 40'h00_770A_BCDE, 1'b1);
  endtask

  task automatic t_backpressure;
    rs_ready = 1'b0;
    @(negedge clk);
    lk_valid = 1'b1; lk_va = 48'h0000_456A_BCDE;
    @(negedge clk);
    lk_va = 48'h0001_DEAD_BEEF;
    check(rs_valid && rs_pa == 40'h00_770A_BCDE, "R8 first", 64'(rs_pa), 64'h770ABCDE);
    check(lk_ready == 1'b0, "R9 ready low", 64'(lk_ready), 64'd0);
    @(negedge clk);
    check(rs_valid && rs_pa == 40'h00_770A_BCDE, "R9 held", 64'(rs_pa), 64'h770ABCDE);
    rs_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check(rs_valid && rs_pa == 40'h20_DEAD_BEEF, "R9 second", 64'(rs_pa), 64'h20DEADBEEF);
    @(negedge clk);
    check(rs_valid == 1'b0, "R9 drained", 64'(rs_valid), 64'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pinned();
    t_pagesize();
    t_region();
    t_cache_fill();
    t_priority();
    t_key();
    t_invalidate();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule